// File: doc/BRIEF.md
# Gradient-Descent Channel Estimate Updater

This block refines a complex channel estimate matrix by one gradient-descent step each time it is started. Every entry of the estimate is recomputed as the old entry minus a power-of-two fraction of the residual: the estimate row is multiplied by one column of a real autocorrelation matrix, and the matching cross-correlation entry is subtracted from that product. No matrix inversion is needed. Repeated starts make the estimate converge, and a tracking loop can issue one start per block of new decisions.

The datapath is built for small area. A single real-by-complex multiply-accumulate unit walks the whole matrix product serially. One subtractor forms the residual. An arithmetic right shift applies the step size, and a saturator clamps the result. The autocorrelation and cross-correlation matrices sit in external storage and are read through address/data ports that respond in the same cycle. The estimate is held in two internal banks. Reads for the product come from the active bank, and new entries go to the other bank. The two banks change roles on the done pulse, so a detector using the read port sees a consistent estimate for the whole update.

The estimate has ROWS rows and COLS columns. The autocorrelation matrix is COLS by COLS, and the cross-correlation matrix is ROWS by COLS. Estimate and autocorrelation entries are 8-bit signed. Cross-correlation parts are 16-bit signed. The step shift is 8.

Top module: `gd_chan_update`

## Requirements
- R1: After reset, busy and done are low and every estimate entry reads zero (real and imaginary) on the read port.
- R2: A start pulse seen while idle begins an update: busy is high from the next cycle until the done cycle, and busy is low while done is high.
- R3: Each new entry (i,j) equals sat(A(i,j) - ((S - X(i,j)) >>> 8)), computed separately for the real and imaginary parts. Here S is the sum over k of A(i,k)*Rbb(k,j), and X is the cross-correlation entry. All A values on the right-hand side are taken from the estimate as it was before the update started.
- R4: The shift by 8 is arithmetic and rounds toward minus infinity. A residual of -1 gives a step of -1, and a residual of +1 gives a step of 0.
- R5: Each result is saturated to the signed 8-bit range [-128, 127] before it is stored.
- R6: done is a one-cycle pulse. It rises exactly ROWS*COLS*(COLS+1) clock edges after the edge that accepts start.
- R7: While an update runs, the read port returns the old estimate. From the done cycle onward it returns the new estimate.
- R8: A start pulse applied while busy is ignored: done timing is unchanged and no second update follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one update (accepted only when idle) |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse when the new estimate becomes active |
| rbb_row | output | clog2(COLS) | Autocorrelation read row |
| rbb_col | output | clog2(COLS) | Autocorrelation read column |
| rbb_data | input | 8 | Autocorrelation entry at (rbb_row, rbb_col), same cycle |
| rbr_row | output | clog2(ROWS) | Cross-correlation read row |
| rbr_col | output | clog2(COLS) | Cross-correlation read column |
| rbr_re | input | 16 | Cross-correlation real part, same cycle |
| rbr_im | input | 16 | Cross-correlation imaginary part, same cycle |
| est_rd_row | input | clog2(ROWS) | Estimate read row |
| est_rd_col | input | clog2(COLS) | Estimate read column |
| est_rd_re | output | 8 | Active estimate real part |
| est_rd_im | output | 8 | Active estimate imaginary part |

## Verification
The assertions assume that start arrives as a pulse and that the correlation storage answers combinationally. They also assume the correlation contents stay fixed for the length of an update, so that the column address held across one entry's accumulation is what the storage sees. The bench models both matrices as arrays indexed directly by the block's address outputs, and it changes their contents only between updates. It sweeps every entry of a small 2-by-4 configuration over patterns that reach saturation, exact and inexact negative shifts, and full-range products. It also drives a stray start pulse partway through an update.

// File: rtl/gdce_pkg.sv
package gdce_pkg;
    localparam int EST_W   = 8;
    localparam int CORR_W  = 8;
    localparam int XC_W    = 16;
    localparam int STEP_SH = 8;
    localparam int EST_MAX = (1 << (EST_W - 1)) - 1;
    localparam int EST_MIN = -(1 << (EST_W - 1));

    typedef struct packed {
        logic signed [EST_W-1:0] re;
        logic signed [EST_W-1:0] im;
    } cplx_est_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MAC   = 2'd1,
        ST_WRITE = 2'd2
    } upd_state_t;

    function automatic logic signed [EST_W-1:0] sat_est(input logic signed [31:0] v);
        if (v > EST_MAX)      return EST_W'(EST_MAX);
        else if (v < EST_MIN) return EST_W'(EST_MIN);
        else                  return v[EST_W-1:0];
    endfunction
endpackage

// File: rtl/gdce_seq.sv
module gdce_seq
    import gdce_pkg::*;
#(
    parameter int ROWS = 2,
    parameter int COLS = 4,
    localparam int RB = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CB = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [RB-1:0] row,
    output logic [CB-1:0] col,
    output logic [CB-1:0] kidx,
    output logic [CB-1:0] a_col,
    output logic          mac_en,
    output logic          mac_first,
    output logic          wr_en,
    output logic          finish
);
    upd_state_t state;

    assign busy      = (state != ST_IDLE);
    assign mac_en    = (state == ST_MAC);
    assign mac_first = (kidx == '0);
    assign wr_en     = (state == ST_WRITE);
    assign a_col     = wr_en ? col : kidx;
    assign finish    = wr_en && (row == RB'(ROWS - 1)) && (col == CB'(COLS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            row   <= '0;
            col   <= '0;
            kidx  <= '0;
            done  <= 1'b0;
        end else begin
            done <= finish;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_MAC;
                        row   <= '0;
                        col   <= '0;
                        kidx  <= '0;
                    end
                end
                ST_MAC: begin
                    if (kidx == CB'(COLS - 1)) begin
                        kidx  <= '0;
                        state <= ST_WRITE;
                    end else begin
                        kidx <= kidx + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (col == CB'(COLS - 1)) begin
                        col <= '0;
                        if (row == RB'(ROWS - 1)) begin
                            row   <= '0;
                            state <= ST_IDLE;
                        end else begin
                            row   <= row + 1'b1;
                            state <= ST_MAC;
                        end
                    end else begin
                        col   <= col + 1'b1;
                        state <= ST_MAC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gdce_mac.sv
module gdce_mac
    import gdce_pkg::*;
#(
    parameter int ACC_W = 19
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     first,
    input  cplx_est_t                a,
    input  logic signed [CORR_W-1:0] coef,
    output logic signed [ACC_W-1:0]  acc_re,
    output logic signed [ACC_W-1:0]  acc_im
);
    localparam int PW = EST_W + CORR_W;

    logic signed [PW-1:0] prod_re, prod_im;

    assign prod_re = PW'(a.re) * PW'(coef);
    assign prod_im = PW'(a.im) * PW'(coef);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (en) begin
            acc_re <= (first ? '0 : acc_re) + ACC_W'(prod_re);
            acc_im <= (first ? '0 : acc_im) + ACC_W'(prod_im);
        end
    end
endmodule

// File: rtl/gdce_bank.sv
module gdce_bank
    import gdce_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swap,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  cplx_est_t     wr_data,
    input  logic [AW-1:0] old_addr,
    output cplx_est_t     old_data,
    input  logic [AW-1:0] ext_addr,
    output cplx_est_t     ext_data,
    output logic          act_sel
);
    cplx_est_t mem [2][DEPTH];

    assign old_data = mem[act_sel][old_addr];
    assign ext_data = mem[act_sel][ext_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            act_sel <= 1'b0;
            for (int b = 0; b < 2; b++)
                for (int d = 0; d < DEPTH; d++)
                    mem[b][d] <= '0;
        end else begin
            if (wr_en) mem[!act_sel][wr_addr] <= wr_data;
            if (swap)  act_sel <= !act_sel;
        end
    end
endmodule

// File: rtl/gd_chan_update.sv
module gd_chan_update
    import gdce_pkg::*;
#(
    parameter int ROWS = 2,
    parameter int COLS = 4,
    localparam int RB = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CB = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output logic                     busy,
    output logic                     done,
    output logic [CB-1:0]            rbb_row,
    output logic [CB-1:0]            rbb_col,
    input  logic signed [CORR_W-1:0] rbb_data,
    output logic [RB-1:0]            rbr_row,
    output logic [CB-1:0]            rbr_col,
    input  logic signed [XC_W-1:0]   rbr_re,
    input  logic signed [XC_W-1:0]   rbr_im,
    input  logic [RB-1:0]            est_rd_row,
    input  logic [CB-1:0]            est_rd_col,
    output logic signed [EST_W-1:0]  est_rd_re,
    output logic signed [EST_W-1:0]  est_rd_im
);
    localparam int DEPTH = ROWS * COLS;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int ACC_W = EST_W + CORR_W + CB + 1;
    localparam int DW    = ((ACC_W > XC_W) ? ACC_W : XC_W) + 2;

    logic [RB-1:0] row;
    logic [CB-1:0] col, kidx, a_col;
    logic mac_en, mac_first, wr_en, finish, act_sel;
    logic signed [ACC_W-1:0] acc_re, acc_im;
    cplx_est_t old_data, ext_data, new_data;
    logic [AW-1:0] old_addr, wr_addr, ext_addr;
    logic signed [DW-1:0] diff_re, diff_im, step_re, step_im, nv_re, nv_im;

    gdce_seq #(.ROWS(ROWS), .COLS(COLS)) u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .row(row), .col(col), .kidx(kidx), .a_col(a_col),
        .mac_en(mac_en), .mac_first(mac_first), .wr_en(wr_en), .finish(finish)
    );

    gdce_mac #(.ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst(rst), .en(mac_en), .first(mac_first),
        .a(old_data), .coef(rbb_data), .acc_re(acc_re), .acc_im(acc_im)
    );

    assign old_addr = AW'(row) * AW'(COLS) + AW'(a_col);
    assign wr_addr  = AW'(row) * AW'(COLS) + AW'(col);
    assign ext_addr = AW'(est_rd_row) * AW'(COLS) + AW'(est_rd_col);

    gdce_bank #(.DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst(rst), .swap(finish), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(new_data),
        .old_addr(old_addr), .old_data(old_data),
        .ext_addr(ext_addr), .ext_data(ext_data), .act_sel(act_sel)
    );

    assign rbb_row   = kidx;
    assign rbb_col   = col;
    assign rbr_row   = row;
    assign rbr_col   = col;
    assign est_rd_re = ext_data.re;
    assign est_rd_im = ext_data.im;

    // residual, truncated step, and saturated update
    always_comb begin
        diff_re     = DW'(acc_re) - DW'(rbr_re);
        diff_im     = DW'(acc_im) - DW'(rbr_im);
        step_re     = diff_re >>> STEP_SH;
        step_im     = diff_im >>> STEP_SH;
        nv_re       = DW'(old_data.re) - step_re;
        nv_im       = DW'(old_data.im) - step_im;
        new_data.re = sat_est(32'(nv_re));
        new_data.im = sat_est(32'(nv_im));
    end
endmodule

// File: rtl/gdce_chk.sv
module gdce_chk #(
    parameter int CB = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          act_sel,
    input logic          mac_en,
    input logic          mac_first,
    input logic [CB-1:0] rbb_col
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    swap_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (act_sel != $past(act_sel)));

    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(act_sel));

    // R3
    col_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mac_en && !mac_first) |-> $stable(rbb_col));
endmodule

bind gd_chan_update gdce_chk #(.CB(CB)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .act_sel(act_sel), .mac_en(mac_en), .mac_first(mac_first), .rbb_col(rbb_col)
);

// File: tb/tb_gd_chan_update.sv
`timescale 1ns/1ps
module tb_gd_chan_update;
    localparam int ROWS = 2;
    localparam int COLS = 4;
    localparam int RB = 1;
    localparam int CB = 2;
    localparam int LAT = ROWS * COLS * (COLS + 1);

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic busy, done;
    logic [CB-1:0] rbb_row, rbb_col, rbr_col, est_rd_col;
    logic [RB-1:0] rbr_row, est_rd_row;
    logic signed [7:0] rbb_data, est_rd_re, est_rd_im;
    logic signed [15:0] rbr_re, rbr_im;

    int rbb_m [COLS][COLS];
    int xr_m [ROWS][COLS];
    int xi_m [ROWS][COLS];
    int ar [ROWS][COLS];
    int ai [ROWS][COLS];
    int checks = 0;
    int errors = 0;
    int seed = 7;

    always #2.5 clk = ~clk;

    assign rbb_data = 8'(rbb_m[rbb_row][rbb_col]);
    assign rbr_re   = 16'(xr_m[rbr_row][rbr_col]);
    assign rbr_im   = 16'(xi_m[rbr_row][rbr_col]);

    gd_chan_update #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .rbb_row(rbb_row), .rbb_col(rbb_col), .rbb_data(rbb_data),
        .rbr_row(rbr_row), .rbr_col(rbr_col), .rbr_re(rbr_re), .rbr_im(rbr_im),
        .est_rd_row(est_rd_row), .est_rd_col(est_rd_col),
        .est_rd_re(est_rd_re), .est_rd_im(est_rd_im)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    function automatic int rnd(input int lo, input int hi);
        seed = seed * 1103515245 + 12345;
        return lo + ((seed >>> 16) & 32'h7fff) % (hi - lo + 1);
    endfunction

    task automatic read_entry(input int i, input int j, output int re, output int im);
        est_rd_row = RB'(i);
        est_rd_col = CB'(j);
        #0.5;
        re = est_rd_re;
        im = est_rd_im;
    endtask

    task automatic run_update(input string req);
        int nr [ROWS][COLS];
        int ni [ROWS][COLS];
        int seen = -1;
        int re, im;
        // expected result from the pre-update estimate
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) begin
                int sr = 0;
                int si = 0;
                for (int k = 0; k < COLS; k++) begin
                    sr += ar[i][k] * rbb_m[k][j];
                    si += ai[i][k] * rbb_m[k][j];
                end
                nr[i][j] = sat8(ar[i][j] - ((sr - xr_m[i][j]) >>> 8));
                ni[i][j] = sat8(ai[i][j] - ((si - xi_m[i][j]) >>> 8));
            end
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        for (int m = 1; m <= LAT + 3; m++) begin
            if (m == 1) check("R2 busy after start", int'(busy), 1);
            if (done && seen < 0) begin
                seen = m;
                check("R2 busy low at done", int'(busy), 0);
            end
            if (seen > 0 && m == seen + 1) begin
                check("R6 done one cycle", int'(done), 0);
                check("R8 no second update", int'(busy), 0);
            end
            if (m == 10) begin
                read_entry(0, 1, re, im);
                check("R7 old estimate during update re", re, ar[0][1]);
                check("R7 old estimate during update im", im, ai[0][1]);
            end
            if (m == 20) begin
                read_entry(1, 3, re, im);
                check("R7 old estimate late re", re, ar[1][3]);
            end
            start = (m == 15);
            @(negedge clk);
        end
        check("R6 done latency", seen, LAT + 1);
        check("R8 idle after stray start", int'(busy), 0);
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) begin
                read_entry(i, j, re, im);
                check(req, re, nr[i][j]);
                check(req, im, ni[i][j]);
                ar[i][j] = nr[i][j];
                ai[i][j] = ni[i][j];
            end
    endtask

    task automatic set_pattern(input int p);
        for (int k = 0; k < COLS; k++)
            for (int j = 0; j < COLS; j++)
                case (p)
                    0: rbb_m[k][j] = 0;
                    1: rbb_m[k][j] = rnd(-128, 127);
                    2: rbb_m[k][j] = (k == j) ? -128 : 0;
                    default: rbb_m[k][j] = 0;
                endcase
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++)
                case (p)
                    0: begin xr_m[i][j] = -300 * (i + j + 1); xi_m[i][j] = 700 * (j - i); end
                    1: begin xr_m[i][j] = rnd(-32768, 32767); xi_m[i][j] = rnd(-32768, 32767); end
                    2: begin xr_m[i][j] = 32767; xi_m[i][j] = -32768; end
                    default: begin
                        xr_m[i][j] = (j % 2 == 0) ? 1 : 256;
                        xi_m[i][j] = (j % 2 == 0) ? -1 : -255;
                    end
                endcase
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int re, im;
        est_rd_row = '0;
        est_rd_col = '0;
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) begin
                ar[i][j] = 0;
                ai[i][j] = 0;
            end
        set_pattern(0);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) begin
                read_entry(i, j, re, im);
                check("R1 zero estimate re", re, 0);
                check("R1 zero estimate im", im, 0);
            end
        // R3 accumulation with zero autocorrelation
        for (int n = 0; n < 2; n++) run_update("R3 entry value");
        // R3 full-range products
        for (int n = 0; n < 4; n++) begin
            set_pattern(1);
            run_update("R3 entry value random");
        end
        // R5 saturation
        set_pattern(2);
        for (int n = 0; n < 3; n++) run_update("R5 saturated entry");
        // R4 floor of small residuals
        set_pattern(3);
        for (int n = 0; n < 3; n++) run_update("R4 truncated step");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule